// File: doc/BRIEF.md
# Write-once system option register

This block is one 8-bit configuration register on a small microcontroller's peripheral bus. The CPU reaches it at a single decoded address through a write strobe with write data and a read strobe with read data. Each field drives one control line for nearby logic: the watchdog enable, the watchdog clock source, permission to enter stop mode, RF enable, temperature-restart enable and wake direction, and the function of the shared debug pin.

Three fields protect the system: watchdog enable, watchdog clock and stop permission. They take effect only on the first write to the register after a reset. A lock flag set by that write freezes them, while the remaining fields stay writable. Two resets act on the block. A power-on reset initialises everything. An MCU reset initialises everything except the RF enable, which keeps its value until the next power-on.

Top module: `sysopt_reg`

## Requirements
- R1: After power-on reset the register reads 0x82: watchdog enable (bit 7) = 1, debug pin select (bit 1) = 1, and all other bits 0.
- R2: A write to any address other than 0x1802 changes no field and does not engage the lock, so a later write to 0x1802 still counts as the first one.
- R3: The first write to 0x1802 after any reset loads bits 7 (watchdog enable), 6 (watchdog clock, 1 = bus clock) and 5 (stop permit) from the write data.
- R4: After that first write, bits 7 to 5 keep their values through every later write until the next reset.
- R5: Bits 4 (RF enable), 3 (temperature restart enable), 2 (restart direction, 1 = high temperature) and 1 (debug pin select) take the write data on every write to 0x1802, whether or not the lock is engaged.
- R6: Bit 0 always reads 0 and ignores written data.
- R7: An MCU reset returns bits 7 to 5 and 3 to 1 to their power-on values and releases the lock, but keeps the value of bit 4.
- R8: A power-on reset clears bit 4.
- R9: Read data shows the register while the read strobe is high with address 0x1802, and shows 0 at any other time.
- R10: Each control output equals its register bit at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| porRst_n | input | 1 | Power-on reset, active low, asynchronous |
| mcuRst_n | input | 1 | MCU reset, active low, asynchronous |
| busAddr | input | 16 | Bus address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 8 | Read data, 0 when not selected |
| wdogEn | output | 1 | Watchdog enable |
| wdogClkSel | output | 1 | Watchdog clock: 0 slow oscillator, 1 bus clock |
| stopAllow | output | 1 | Stop mode permitted |
| rfEn | output | 1 | RF module enable |
| tempRestartEn | output | 1 | Temperature restart enable |
| tempRestartHigh | output | 1 | Restart direction: 1 high, 0 low temperature |
| debugPinSel | output | 1 | 1 debug function, 0 general-purpose output |

## Verification
The hardest state to reach is RF enable set to 1 while the other fields hold a locked mix of values. An MCU reset then has to restore the defaults and release the lock while leaving RF enable at 1. The stimulus writes RF enable high after the lock has engaged and then pulses only the MCU reset. It checks that the next write is accepted as a first write. It also places a write to a neighbouring address just after a reset, to show that only a write at the decoded address engages the lock.

// File: rtl/sysopt_pkg.sv
package sysopt_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] REG_ADDR = 16'h1802;

  localparam int BIT_WDOG_EN  = 7;
  localparam int BIT_WDOG_CLK = 6;
  localparam int BIT_STOP     = 5;
  localparam int BIT_RF       = 4;
  localparam int BIT_TR_EN    = 3;
  localparam int BIT_TR_HIGH  = 2;
  localparam int BIT_DBG      = 1;

  // strobes from control to datapath
  typedef struct packed {
    logic wrFree;  // write hit: free fields load
    logic wrOnce;  // write hit with lock clear: guarded fields load
    logic rdHit;   // read hit: drive read data
  } sysopt_strb_t;
endpackage

// File: rtl/sysopt_ctrl.sv
module sysopt_ctrl
  import sysopt_pkg::*;
(
  input  logic              clk,
  input  logic              rstAll_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output sysopt_strb_t      strb
);
  logic addrHit;
  logic lockSet;

  assign addrHit = (busAddr == REG_ADDR);

  always_ff @(posedge clk or negedge rstAll_n) begin
    if (!rstAll_n) lockSet <= 1'b0;
    else if (busWrEn && addrHit) lockSet <= 1'b1;
  end

  always_comb begin
    strb.wrFree = busWrEn && addrHit;
    strb.wrOnce = busWrEn && addrHit && !lockSet;
    strb.rdHit  = busRdEn && addrHit;
  end
endmodule

// File: rtl/sysopt_dp.sv
module sysopt_dp
  import sysopt_pkg::*;
(
  input  logic              clk,
  input  logic              porRst_n,
  input  logic              rstAll_n,
  input  sysopt_strb_t      strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] fields
);
  localparam logic [2:0] ONCE_RST = 3'b100;
  localparam logic [2:0] FREE_RST = 3'b001; // bits 3..1

  logic [2:0] onceQ;  // bits 7..5
  logic       rfQ;    // bit 4
  logic [2:0] freeQ;  // bits 3..1

  always_ff @(posedge clk or negedge rstAll_n) begin
    if (!rstAll_n) onceQ <= ONCE_RST;
    else if (strb.wrOnce) onceQ <= wrData[BIT_WDOG_EN:BIT_STOP];
  end

  always_ff @(posedge clk or negedge rstAll_n) begin
    if (!rstAll_n) freeQ <= FREE_RST;
    else if (strb.wrFree) freeQ <= wrData[BIT_TR_EN:BIT_DBG];
  end

  // only power-on reaches this bit
  always_ff @(posedge clk or negedge porRst_n) begin
    if (!porRst_n) rfQ <= 1'b0;
    else if (strb.wrFree) rfQ <= wrData[BIT_RF];
  end

  assign fields = {onceQ, rfQ, freeQ, 1'b0};
  assign rdData = strb.rdHit ? fields : '0;
endmodule

// File: rtl/sysopt_reg.sv
module sysopt_reg
  import sysopt_pkg::*;
(
  input  logic              clk,
  input  logic              porRst_n,
  input  logic              mcuRst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData,
  output logic              wdogEn,
  output logic              wdogClkSel,
  output logic              stopAllow,
  output logic              rfEn,
  output logic              tempRestartEn,
  output logic              tempRestartHigh,
  output logic              debugPinSel
);
  logic              rstAll_n;
  sysopt_strb_t      strb;
  logic [DATA_W-1:0] fields;

  assign rstAll_n = porRst_n & mcuRst_n;

  sysopt_ctrl ctrl_i (
    .clk      (clk),
    .rstAll_n (rstAll_n),
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .busRdEn  (busRdEn),
    .strb     (strb)
  );

  sysopt_dp dp_i (
    .clk      (clk),
    .porRst_n (porRst_n),
    .rstAll_n (rstAll_n),
    .strb     (strb),
    .wrData   (busWrData),
    .rdData   (busRdData),
    .fields   (fields)
  );

  assign wdogEn          = fields[BIT_WDOG_EN];
  assign wdogClkSel      = fields[BIT_WDOG_CLK];
  assign stopAllow       = fields[BIT_STOP];
  assign rfEn            = fields[BIT_RF];
  assign tempRestartEn   = fields[BIT_TR_EN];
  assign tempRestartHigh = fields[BIT_TR_HIGH];
  assign debugPinSel     = fields[BIT_DBG];
endmodule

// File: rtl/sysopt_chk.sv
module sysopt_chk
  import sysopt_pkg::*;
(
  input logic              clk,
  input logic              porRst_n,
  input logic              mcuRst_n,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [DATA_W-1:0] busWrData,
  input logic              busRdEn,
  input logic [DATA_W-1:0] busRdData,
  input logic              wdogEn,
  input logic              wdogClkSel,
  input logic              stopAllow,
  input logic              rfEn,
  input logic              tempRestartEn,
  input logic              tempRestartHigh,
  input logic              debugPinSel
);
  logic rstOn;
  logic seenWr;
  logic wrHit;
  logic [DATA_W-1:0] outVec;

  assign rstOn  = !porRst_n || !mcuRst_n;
  assign wrHit  = busWrEn && (busAddr == REG_ADDR);
  assign outVec = {wdogEn, wdogClkSel, stopAllow, rfEn,
                   tempRestartEn, tempRestartHigh, debugPinSel, 1'b0};

  // checker's own record of a first write since reset
  always_ff @(posedge clk or posedge rstOn) begin
    if (rstOn) seenWr <= 1'b0;
    else if (wrHit) seenWr <= 1'b1;
  end

  assert_miss_stable_R2: assert property (@(posedge clk) disable iff (rstOn)
    (busWrEn && busAddr != REG_ADDR) |=> $stable(outVec));

  assert_first_write_R3: assert property (@(posedge clk) disable iff (rstOn)
    (wrHit && !seenWr) |=> {wdogEn, wdogClkSel, stopAllow} == $past(busWrData[7:5]));

  assert_locked_R4: assert property (@(posedge clk) disable iff (rstOn)
    (wrHit && seenWr) |=> $stable({wdogEn, wdogClkSel, stopAllow}));

  assert_free_write_R5: assert property (@(posedge clk) disable iff (rstOn)
    wrHit |=> {rfEn, tempRestartEn, tempRestartHigh, debugPinSel} == $past(busWrData[4:1]));

  assert_rsvd_zero_R6: assert property (@(posedge clk) disable iff (rstOn)
    busRdData[0] == 1'b0);

  assert_read_idle_R9: assert property (@(posedge clk) disable iff (rstOn)
    !(busRdEn && busAddr == REG_ADDR) |-> busRdData == '0);

  assert_read_mirror_R10: assert property (@(posedge clk) disable iff (rstOn)
    (busRdEn && busAddr == REG_ADDR) |-> busRdData == outVec);
endmodule

bind sysopt_reg sysopt_chk chk_i (.*);

// File: tb/sysopt_reg_tb_top.sv
module sysopt_reg_tb_top;
  logic        clk = 1'b0;
  logic        porRst_n = 1'b0;
  logic        mcuRst_n = 1'b1;
  logic [15:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [7:0]  busRdData;
  logic wdogEn, wdogClkSel, stopAllow, rfEn, tempRestartEn, tempRestartHigh, debugPinSel;

  localparam logic [15:0] ADDR = 16'h1802;

  int checks = 0;
  int failures = 0;

  // requirement-level model
  logic [7:0] mReg = 8'h82;
  logic       mLock = 1'b0;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;
  exp_t expQ[$];

  always #2 clk = ~clk;

  sysopt_reg dut_i (.*);

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every read cycle
  always @(negedge clk) begin
    if (busRdEn) begin
      exp_t e;
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL R9 actual=unexpected read expected=queued item");
      end else begin
        e = expQ.pop_front();
        check(e.tag, busRdData, e.val);
      end
    end
  end

  task automatic busWrite(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0;
    if (a == ADDR) begin
      if (!mLock) mReg[7:5] = d[7:5];
      mReg[4:1] = d[4:1];
      mLock = 1'b1;
    end
  endtask

  task automatic busRead(input logic [15:0] a, input string tag);
    exp_t e;
    @(posedge clk); #1;
    busAddr = a; busRdEn = 1'b1;
    e.val = (a == ADDR) ? mReg : 8'h00;
    e.tag = tag;
    expQ.push_back(e);
    @(posedge clk); #1;
    busRdEn = 1'b0;
  endtask

  task automatic checkOuts(input string tag);
    @(negedge clk);
    check(tag, {wdogEn, wdogClkSel, stopAllow, rfEn, tempRestartEn,
                tempRestartHigh, debugPinSel, 1'b0}, mReg);
  endtask

  task automatic pulseMcu();
    @(posedge clk); #1; mcuRst_n = 1'b0;
    repeat (2) @(posedge clk); #1; mcuRst_n = 1'b1;
    mReg = {3'b100, mReg[4], 4'b0010};
    mLock = 1'b0;
  endtask

  task automatic pulsePor();
    @(posedge clk); #1; porRst_n = 1'b0;
    repeat (2) @(posedge clk); #1; porRst_n = 1'b1;
    mReg = 8'h82;
    mLock = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    porRst_n = 1'b1;
    checkOuts("R1 reset outputs");
    busRead(ADDR, "R1 reset value");

    busWrite(16'h1803, 8'hFF);
    busRead(ADDR, "R2 miss write ignored");
    busWrite(ADDR, 8'h00);
    busRead(ADDR, "R3 first write after miss");
    busWrite(ADDR, 8'hFF);
    busRead(ADDR, "R4 R5 R6 locked bits held, free bits set");
    busWrite(ADDR, 8'h00);
    busRead(ADDR, "R5 free bits cleared");
    busWrite(ADDR, 8'hF0);
    busRead(ADDR, "R5 rf on under lock");

    pulseMcu();
    busRead(ADDR, "R7 mcu reset keeps rf");
    busRead(16'h1800, "R9 read other address");
    busWrite(ADDR, 8'h60);
    busRead(ADDR, "R3 R7 lock released by mcu reset");
    checkOuts("R10 outputs mirror");
    busWrite(ADDR, 8'h8C);
    busRead(ADDR, "R4 second write guarded");
    checkOuts("R10 outputs after mix");

    busWrite(ADDR, 8'h10);
    pulsePor();
    busRead(ADDR, "R8 por clears rf");
    checkOuts("R8 outputs after por");

    for (int i = 0; i < 6; i++) begin
      logic [7:0] v;
      v = 8'h35 * (i + 3);
      busWrite(ADDR, v);
      busRead(ADDR, "R3 R4 R5 pattern");
      if (i == 2) pulseMcu();
    end
    checkOuts("R10 final");

    repeat (4) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule